// File: doc/BRIEF.md
# Elastic Mesh Processing Element

This block is one tile of a coarse-grained reconfigurable array. It talks to its four mesh neighbours (north, east, south, west) over valid/ready channels that tolerate any latency. Every incoming channel lands in a small elastic queue. A static configuration word chooses one 32-bit operation, where its two operands come from (any queue or a local register), which outputs receive its result, and a set of pass-through routes. A pass-through route sends the head of any input queue to any output, so traffic can cross a tile that is busy computing something else.

An operation fires only when everything it needs is present. Each operand it reads must be available, and every output it drives must be ready. Its result then appears on all of its outputs in the same cycle. The local register either holds a constant taken from the configuration word or gathers the operator result, which supports running reductions across loop iterations. The tile checks the configuration after reset through a small controller. The controller has three states. `ST_CHECK` lasts one cycle after reset. On transition `T_CFG_OK` it moves to `ST_RUN`, and on `T_CFG_BAD` it moves to `ST_FAULT`. From `ST_RUN`, transition `T_RUN_BAD` leads to `ST_FAULT`. `ST_FAULT` is left only by reset. In `ST_FAULT` nothing moves.

Configuration word layout, most significant field first:
- constant, bits 44:29
- register-holds-constant, bit 28
- register-write, bit 27
- route enable per output, bits 26:23
- route source per output, 2 bits each, bits 22:15, with output d at 16+2d:15+2d
- operator output mask, bits 14:11
- operand B select, bits 10:8
- operand A select, bits 7:5
- operator enable, bit 4
- opcode, bits 3:0

Direction index: 0 north, 1 east, 2 south, 3 west. The same index is used for bit d of every 4-bit port vector and for lane d of the data ports.

Top module: `mesh_tile`

## Requirements
- R1: Each direction has an input queue of two entries. After reset every `in_ready` bit is 1. A queue holding two items that are not being consumed drops its `in_ready` in that cycle. A full queue that is being drained in the same cycle keeps `in_ready` high and accepts a new item.
- R2: Items that leave through a route or are consumed by the operator leave each queue in arrival order. None is lost and none is duplicated.
- R3: When route enable d is 1, output d carries the head of the queue named by route source d. This happens whether or not the operator is firing.
- R4: The operator fires only when all of the following hold:
  - every selected operand source is available;
  - every output in its mask has `out_ready` high;
  - the controller is in `ST_RUN`.

  When it fires, all masked outputs show `out_valid` with the result in that one cycle. One item is dequeued from each distinct operand queue. Otherwise those outputs show `out_valid` low.
- R5: Opcode encodings:
  - 0 add
  - 1 subtract (A−B)
  - 2 AND
  - 3 OR
  - 4 XOR
  - 5 shift left of A by B[4:0]
  - 6 logical shift right of A by B[4:0]
  - 7 equal (result 1 or 0)
  - 8 unsigned A<B (result 1 or 0)
  - 9–15 pass A
- R6: Operand select values 0–3 name the north/east/south/west queue. Value 4 names the local register, which is always available.
- R7: With register-holds-constant at 0 and register-write at 1, each firing loads the result into the register. The register is 0 after reset.
- R8: With register-holds-constant at 1, the register holds the 16-bit constant zero-extended while running.
- R9: The configuration is bad in any of these cases:
  - an enabled operator uses a select above 4;
  - an enabled operator's mask overlaps the route enables;
  - a queue has more than one consumer.

  A bad configuration sets `cfg_err` to 1. While `cfg_err` is 1, no `out_valid` is raised and no queue is drained. `cfg_err` stays set until reset.
- R10: During reset and in the single `ST_CHECK` cycle after it, every `out_valid` is 0 and `cfg_err` is 0.
- R11: A routed output that is valid but not ready stays valid with unchanged data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 45 | Static configuration word, held stable outside reset |
| in_valid | input | 4 | Per-direction incoming item present |
| in_ready | output | 4 | Per-direction queue can accept |
| in_data | input | 4×DW (128) | Per-direction incoming data, lane d for direction d |
| out_valid | output | 4 | Per-direction outgoing item present |
| out_ready | input | 4 | Per-direction neighbour can accept |
| out_data | output | 4×DW (128) | Per-direction outgoing data |
| cfg_err | output | 1 | Configuration rejected, sticky until reset |

## Verification
Several internal faults can occur, and each shows at the ports in its own way:

- Queue pointers or counts that have drifted duplicate or drop items. The scoreboard sees this on the next transfer from that direction, as an out-of-order value or as an output with no pending item behind it.
- Wrong firing logic makes masked outputs disagree within a single cycle. It can also consume an operand that is not paired correctly, which corrupts every later result on that operator.
- A corrupted register shows up in the first result that reads it.
- A controller stuck in the wrong state shows up one cycle after reset, either as an unexpected `cfg_err` or as outputs that never go valid.

// File: rtl/tile_pkg.sv
`timescale 1ns/1ps
package tile_pkg;

    localparam int NDIR = 4;
    localparam logic [2:0] SEL_REG = 3'd4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_EQ  = 4'd7,
        OP_LTU = 4'd8
    } opcode_e;

    typedef struct packed {
        logic [15:0]      konst;
        logic             reg_const;
        logic             reg_wr;
        logic [3:0]       byp_en;
        logic [3:0][1:0]  byp_src;
        logic [3:0]       op_dst;
        logic [2:0]       src_b;
        logic [2:0]       src_a;
        logic             op_en;
        logic [3:0]       opcode;
    } tile_cfg_t;

    localparam int CFG_W = $bits(tile_cfg_t);

    typedef enum logic [1:0] {
        ST_CHECK = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } tile_state_e;

    function automatic logic cfg_invalid(tile_cfg_t c);
        logic bad;
        int   users;
        bad = 1'b0;
        if (c.op_en) begin
            if (c.src_a > SEL_REG || c.src_b > SEL_REG) bad = 1'b1;
            if ((c.op_dst & c.byp_en) != 4'b0) bad = 1'b1;
        end
        for (int q = 0; q < NDIR; q++) begin
            users = 0;
            if (c.op_en && (c.src_a == 3'(q) || c.src_b == 3'(q))) users++;
            for (int d = 0; d < NDIR; d++) begin
                if (c.byp_en[d] && c.byp_src[d] == 2'(q)) users++;
            end
            if (users > 1) bad = 1'b1;
        end
        return bad;
    endfunction

endpackage

// File: rtl/tile_queue.sv
`timescale 1ns/1ps
module tile_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          head_valid,
    output logic [DW-1:0] head_data,
    input  logic          deq,
    output logic [CW-1:0] level
);

    logic [DW-1:0] slot [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] cnt;
    logic          full;
    logic          push;
    logic          pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        full       = (cnt == CW'(DEPTH));
        head_valid = (cnt != '0);
        head_data  = slot[rd_ptr];
        in_ready   = !full || deq;
        push       = in_valid && in_ready;
        pop        = deq && head_valid;
        level      = cnt;
    end

    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/tile_alu.sv
`timescale 1ns/1ps
module tile_alu
    import tile_pkg::*;
#(
    parameter int DW  = 32,
    localparam int SHW = $clog2(DW)
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);

    logic [SHW-1:0] amt;

    always_comb begin
        amt = b[SHW-1:0];
        case (opcode_e'(op))
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SHL:  res = a << amt;
            OP_SHR:  res = a >> amt;
            OP_EQ:   res = DW'(a == b);
            OP_LTU:  res = DW'(a < b);
            default: res = a;
        endcase
    end

endmodule

// File: rtl/tile_route.sv
`timescale 1ns/1ps
module tile_route
    import tile_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 run,
    input  logic                 op_en,
    input  logic [2:0]           src_a,
    input  logic [2:0]           src_b,
    input  logic [3:0]           op_dst,
    input  logic [3:0]           byp_en,
    input  logic [3:0][1:0]      byp_src,
    input  logic [3:0]           q_valid,
    input  logic [3:0][DW-1:0]   q_data,
    input  logic [DW-1:0]        reg_q,
    input  logic [DW-1:0]        alu_res,
    input  logic [3:0]           out_ready,
    output logic [3:0]           deq,
    output logic [3:0]           out_valid,
    output logic [3:0][DW-1:0]   out_data,
    output logic                 op_fire,
    output logic [DW-1:0]        opnd_a,
    output logic [DW-1:0]        opnd_b
);

    logic       a_ok;
    logic       b_ok;
    logic       dst_ok;
    logic [3:0] byp_fire;

    // Operand muxes: four queues plus the local register
    always_comb begin
        a_ok   = (src_a == SEL_REG) ? 1'b1  : q_valid[src_a[1:0]];
        b_ok   = (src_b == SEL_REG) ? 1'b1  : q_valid[src_b[1:0]];
        opnd_a = (src_a == SEL_REG) ? reg_q : q_data[src_a[1:0]];
        opnd_b = (src_b == SEL_REG) ? reg_q : q_data[src_b[1:0]];
    end

    always_comb begin
        dst_ok  = &(out_ready | ~op_dst);
        op_fire = run && op_en && a_ok && b_ok && dst_ok;
    end

    always_comb begin
        for (int d = 0; d < NDIR; d++) begin
            byp_fire[d] = run && byp_en[d] && q_valid[byp_src[d]] && out_ready[d];
        end
    end

    always_comb begin
        for (int d = 0; d < NDIR; d++) begin
            if (byp_en[d])
                out_valid[d] = run && q_valid[byp_src[d]];
            else if (op_en && op_dst[d])
                out_valid[d] = op_fire;
            else
                out_valid[d] = 1'b0;
        end
    end

    always_comb begin
        for (int d = 0; d < NDIR; d++) begin
            out_data[d] = byp_en[d] ? q_data[byp_src[d]] : alu_res;
        end
    end

    always_comb begin
        for (int q = 0; q < NDIR; q++) begin
            deq[q] = op_fire && (src_a == 3'(q) || src_b == 3'(q));
            for (int d = 0; d < NDIR; d++) begin
                if (byp_fire[d] && byp_src[d] == 2'(q)) deq[q] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mesh_tile.sv
`timescale 1ns/1ps
module mesh_tile
    import tile_pkg::*;
#(
    parameter int DW     = 32,
    parameter int QDEPTH = 2,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [3:0]            in_valid,
    output logic [3:0]            in_ready,
    input  logic [3:0][DW-1:0]    in_data,
    output logic [3:0]            out_valid,
    input  logic [3:0]            out_ready,
    output logic [3:0][DW-1:0]    out_data,
    output logic                  cfg_err
);

    tile_cfg_t             cfg;
    tile_state_e           state_q;
    tile_state_e           state_d;
    logic                  cfg_bad;
    logic                  run;
    logic [3:0]            q_valid;
    logic [3:0][DW-1:0]    q_data;
    logic [3:0]            deq;
    logic [3:0][CNT_W-1:0] q_cnt;
    logic [DW-1:0]         reg_q;
    logic [DW-1:0]         opnd_a;
    logic [DW-1:0]         opnd_b;
    logic [DW-1:0]         alu_res;
    logic                  op_fire;

    always_comb begin
        cfg     = tile_cfg_t'(cfg_word);
        cfg_bad = cfg_invalid(cfg);
    end

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CHECK;
        else        state_q <= state_d;
    end

    // Controller: transitions T_CFG_OK, T_CFG_BAD, T_RUN_BAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHECK: state_d = cfg_bad ? ST_FAULT : ST_RUN;
            ST_RUN:   if (cfg_bad) state_d = ST_FAULT;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // Controller: outputs
    always_comb begin
        run     = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_CHECK: ;
            ST_RUN:   run = 1'b1;
            ST_FAULT: cfg_err = 1'b1;
            default:  cfg_err = 1'b1;
        endcase
    end

    for (genvar q = 0; q < NDIR; q++) begin : g_queue
        tile_queue #(.DW(DW), .DEPTH(QDEPTH)) queue_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[q]),
            .in_ready   (in_ready[q]),
            .in_data    (in_data[q]),
            .head_valid (q_valid[q]),
            .head_data  (q_data[q]),
            .deq        (deq[q]),
            .level      (q_cnt[q])
        );
    end

    tile_route #(.DW(DW)) route_i (
        .run       (run),
        .op_en     (cfg.op_en),
        .src_a     (cfg.src_a),
        .src_b     (cfg.src_b),
        .op_dst    (cfg.op_dst),
        .byp_en    (cfg.byp_en),
        .byp_src   (cfg.byp_src),
        .q_valid   (q_valid),
        .q_data    (q_data),
        .reg_q     (reg_q),
        .alu_res   (alu_res),
        .out_ready (out_ready),
        .deq       (deq),
        .out_valid (out_valid),
        .out_data  (out_data),
        .op_fire   (op_fire),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b)
    );

    tile_alu #(.DW(DW)) alu_i (
        .op  (cfg.opcode),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (alu_res)
    );

    // Multi-purpose register: constant or accumulated result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_q <= '0;
        else if (cfg.reg_const)
            reg_q <= DW'(cfg.konst);
        else if (op_fire && cfg.reg_wr)
            reg_q <= alu_res;
    end

endmodule

// File: rtl/mesh_tile_chk.sv
`timescale 1ns/1ps
module mesh_tile_chk
    import tile_pkg::*;
#(
    parameter int DW     = 32,
    parameter int QDEPTH = 2,
    parameter int CNT_W  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [3:0]            byp_en,
    input logic [3:0]            op_dst,
    input logic                  op_en,
    input logic                  reg_const,
    input logic [15:0]           konst,
    input logic [3:0]            out_valid,
    input logic [3:0]            out_ready,
    input logic [3:0][DW-1:0]    out_data,
    input logic                  cfg_err,
    input logic [3:0][CNT_W-1:0] q_cnt,
    input logic [DW-1:0]         reg_q,
    input tile_state_e           state_q
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt[0] <= CNT_W'(QDEPTH)) && (q_cnt[1] <= CNT_W'(QDEPTH)) &&
        (q_cnt[2] <= CNT_W'(QDEPTH)) && (q_cnt[3] <= CNT_W'(QDEPTH))); // R1

    AST_OP_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        op_en |-> ((out_valid & ~out_ready & op_dst & ~byp_en) == 4'b0)); // R4

    AST_CONST_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_const && state_q == ST_RUN) |-> (reg_q == DW'(konst))); // R8

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (out_valid == 4'b0)); // R9

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R9

    AST_CHECK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> (state_q != ST_CHECK)); // R10

    AST_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |-> (out_valid == 4'b0 && !cfg_err)); // R10

    for (genvar d = 0; d < 4; d++) begin : g_hold
        AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (byp_en[d] && out_valid[d] && !out_ready[d])
            |=> (out_valid[d] && $stable(out_data[d]))); // R11
    end

endmodule

bind mesh_tile mesh_tile_chk #(.DW(DW), .QDEPTH(QDEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byp_en    (cfg.byp_en),
    .op_dst    (cfg.op_dst),
    .op_en     (cfg.op_en),
    .reg_const (cfg.reg_const),
    .konst     (cfg.konst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cfg_err   (cfg_err),
    .q_cnt     (q_cnt),
    .reg_q     (reg_q),
    .state_q   (state_q)
);

// File: tb/mesh_tile_tb_top.sv
`timescale 1ns/1ps
module mesh_tile_tb_top;
    import tile_pkg::*;

    localparam int DW = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CFG_W-1:0]   cfg_word = '0;
    logic [3:0]         in_valid = '0;
    logic [3:0]         in_ready;
    logic [3:0][DW-1:0] in_data = '0;
    logic [3:0]         out_valid;
    logic [3:0]         out_ready = '0;
    logic [3:0][DW-1:0] out_data;
    logic               cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tile_cfg_t     cur;
    logic [DW-1:0] reg_m;
    logic [DW-1:0] sent_q [4][$];

    always #2 clk = ~clk;

    mesh_tile #(.DW(DW), .QDEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cfg_err(cfg_err)
    );

    task automatic check_eq(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] alu_model(logic [3:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[4:0];
            4'd6: return a >> b[4:0];
            4'd7: return (a == b) ? 1 : 0;
            4'd8: return (a < b) ? 1 : 0;
            default: return a;
        endcase
    endfunction

    // Applies a configuration under reset; returns at a negedge in the first run cycle
    task automatic do_reset(tile_cfg_t c);
        @(negedge clk);
        rst_n     = 1'b0;
        cfg_word  = c;
        cur       = c;
        in_valid  = '0;
        out_ready = '0;
        reg_m     = c.reg_const ? DW'(c.konst) : '0;
        for (int i = 0; i < 4; i++) sent_q[i].delete();
        repeat (3) @(negedge clk);
        check_eq("R10", "out_valid in reset", DW'(out_valid), 0);
        check_eq("R10", "cfg_err in reset", DW'(cfg_err), 0);
        rst_n = 1'b1;
        #1;
        check_eq("R10", "out_valid in check state", DW'(out_valid), 0);
        check_eq("R1", "in_ready after reset", DW'(in_ready), DW'(4'hF));
        @(negedge clk);
    endtask

    task automatic pop_src(logic [2:0] sel, output logic [DW-1:0] v, output bit ok);
        ok = 1'b1;
        if (sel == SEL_REG) v = reg_m;
        else if (sent_q[sel[1:0]].size() == 0) begin v = '0; ok = 1'b0; end
        else v = sent_q[sel[1:0]].pop_front();
    endtask

    // Monitor: compares every transfer in this cycle against the scoreboard
    task automatic observe(string op_req);
        logic [3:0]    op_obs;
        logic [DW-1:0] a, b, e;
        bit            oka, okb;
        int            s;
        op_obs = cur.op_en ? (out_valid & out_ready & cur.op_dst) : 4'b0;
        if (op_obs != 4'b0) begin
            check_eq("R4", "multicast mask", DW'(op_obs), DW'(cur.op_dst));
            pop_src(cur.src_a, a, oka);
            if (cur.src_b == cur.src_a) begin b = a; okb = oka; end
            else pop_src(cur.src_b, b, okb);
            if (!oka || !okb) begin
                checks++; errors++;
                $display("FAIL R2 operator result without operands actual=%h expected=none", out_data[0]);
            end else begin
                e = alu_model(cur.opcode, a, b);
                if (cur.reg_wr && !cur.reg_const) reg_m = e;
                for (int d = 0; d < 4; d++)
                    if (op_obs[d]) check_eq(op_req, "operator result", out_data[d], e);
            end
        end
        for (int d = 0; d < 4; d++) begin
            if (cur.byp_en[d] && out_valid[d] && out_ready[d]) begin
                s = int'(cur.byp_src[d]);
                if (sent_q[s].size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 duplicate on route %0d actual=%h expected=none", d, out_data[d]);
                end else begin
                    check_eq("R3", "routed item", out_data[d], sent_q[s].pop_front());
                end
            end
        end
    endtask

    // Driver: random valid on used inputs, random stalls on all outputs, then drain
    task automatic run_traffic(bit [3:0] used, int ncyc, int items, int stall_pct, string op_req);
        int            sent_n [4];
        bit            pend [4];
        logic [DW-1:0] cdat [4];
        int            a_q, b_q;
        for (int i = 0; i < 4; i++) begin sent_n[i] = 0; pend[i] = 0; cdat[i] = '0; end
        for (int cyc = 0; cyc < ncyc + 40; cyc++) begin
            for (int i = 0; i < 4; i++) begin
                if (used[i] && !pend[i] && cyc < ncyc && sent_n[i] < items && ($urandom % 100) < 70) begin
                    pend[i] = 1;
                    cdat[i] = $urandom;
                end
                in_valid[i] = pend[i];
                in_data[i]  = cdat[i];
            end
            for (int d = 0; d < 4; d++)
                out_ready[d] = (cyc >= ncyc) ? 1'b1 : (($urandom % 100) >= stall_pct);
            #1;
            for (int i = 0; i < 4; i++) begin
                if (in_valid[i] && in_ready[i]) begin
                    sent_q[i].push_back(in_data[i]);
                    sent_n[i]++;
                    pend[i] = 0;
                end
            end
            observe(op_req);
            @(negedge clk);
        end
        in_valid = '0;
        for (int d = 0; d < 4; d++)
            if (cur.byp_en[d])
                check_eq("R2", "route source drained", DW'(sent_q[cur.byp_src[d]].size()), 0);
        if (cur.op_en) begin
            a_q = (cur.src_a == SEL_REG) ? 0 : sent_q[cur.src_a[1:0]].size();
            b_q = (cur.src_b == SEL_REG) ? 0 : sent_q[cur.src_b[1:0]].size();
            if (cur.src_a == SEL_REG) a_q = b_q;
            if (cur.src_b == SEL_REG) b_q = a_q;
            check_eq("R2", "operands paired", DW'((a_q < b_q) ? a_q : b_q), 0);
        end
    endtask

    task automatic alu_case(logic [3:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        in_valid[0] = 1; in_data[0] = a;
        in_valid[1] = 1; in_data[1] = b;
        out_ready   = 4'b0100;
        @(negedge clk);
        in_valid = '0;
        #1;
        check_eq("R5", $sformatf("op %0d valid", op), DW'(out_valid[2]), 1);
        check_eq("R5", $sformatf("op %0d result", op), out_data[2], alu_model(op, a, b));
        @(negedge clk);
        #1;
        check_eq("R4", "no repeat after firing", DW'(out_valid[2]), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tile_cfg_t c;

        // Opcode sweep: A=north, B=east, result to south
        for (int op = 0; op < 10; op++) begin
            c = '0; c.op_en = 1; c.opcode = 4'(op);
            c.src_a = 3'd0; c.src_b = 3'd1; c.op_dst = 4'b0100;
            do_reset(c);
            check_eq("R9", "good config accepted", DW'(cfg_err), 0);
            alu_case(4'(op), 32'h0000_0007, 32'h0000_0003);
            alu_case(4'(op), 32'h0000_0003, 32'hFFFF_FFF4);
            alu_case(4'(op), 32'h1234_5678, 32'h1234_5678);
        end

        // R4: partial operands and blocked destination
        c = '0; c.op_en = 1; c.opcode = 4'd0; c.src_a = 3'd0; c.src_b = 3'd1; c.op_dst = 4'b0100;
        do_reset(c);
        out_ready = 4'b1111;
        in_valid[0] = 1; in_data[0] = 32'd40;
        @(negedge clk); in_valid = '0; #1;
        check_eq("R4", "waits for operand B", DW'(out_valid[2]), 0);
        out_ready = 4'b0000;
        in_valid[1] = 1; in_data[1] = 32'd2;
        @(negedge clk); in_valid = '0; #1;
        check_eq("R4", "waits for ready destination", DW'(out_valid[2]), 0);
        out_ready = 4'b0100; #1;
        check_eq("R4", "fires once ready", DW'(out_valid[2]), 1);
        check_eq("R4", "held operands summed", out_data[2], 32'd42);
        @(negedge clk);

        // R1: full queue drained in the same cycle still accepts
        c = '0; c.byp_en[2] = 1; c.byp_src[2] = 2'd0;
        do_reset(c);
        in_valid[0] = 1; in_data[0] = 32'hA1;
        @(negedge clk); in_data[0] = 32'hA2;
        @(negedge clk); in_data[0] = 32'hA3; #1;
        check_eq("R1", "full queue ready low", DW'(in_ready[0]), 0);
        out_ready[2] = 1; #1;
        check_eq("R1", "full queue ready while draining", DW'(in_ready[0]), 1);
        check_eq("R2", "first item out", out_data[2], 32'hA1);
        @(negedge clk); in_valid = '0; #1;
        check_eq("R2", "second item out", out_data[2], 32'hA2);
        @(negedge clk); #1;
        check_eq("R2", "third item out", out_data[2], 32'hA3);
        @(negedge clk); #1;
        check_eq("R2", "queue empty", DW'(out_valid[2]), 0);

        // Traffic A: route north->south, add east+west multicast to north and east
        c = '0; c.op_en = 1; c.opcode = 4'd0; c.src_a = 3'd1; c.src_b = 3'd3; c.op_dst = 4'b0011;
        c.byp_en[2] = 1; c.byp_src[2] = 2'd0;
        do_reset(c);
        run_traffic(4'b1011, 800, 60, 35, "R4");

        // Traffic B: running sum north+register to east, route south->west (R7)
        c = '0; c.op_en = 1; c.opcode = 4'd0; c.src_a = 3'd0; c.src_b = SEL_REG; c.op_dst = 4'b0010;
        c.reg_wr = 1; c.byp_en[3] = 1; c.byp_src[3] = 2'd2;
        do_reset(c);
        run_traffic(4'b0101, 800, 60, 35, "R7");

        // Traffic C: south minus constant 5 to west, routes east->north and west->south (R8, R6)
        c = '0; c.op_en = 1; c.opcode = 4'd1; c.src_a = 3'd2; c.src_b = SEL_REG; c.op_dst = 4'b1000;
        c.reg_const = 1; c.konst = 16'd5;
        c.byp_en[0] = 1; c.byp_src[0] = 2'd1; c.byp_en[2] = 1; c.byp_src[2] = 2'd3;
        do_reset(c);
        in_valid[0] = 1; in_data[0] = 32'h77;
        for (int k = 0; k < 3; k++) begin
            #1;
            check_eq("R1", $sformatf("unused queue ready step %0d", k), DW'(in_ready[0]), (k < 2) ? 1 : 0);
            @(negedge clk);
        end
        in_valid = '0;
        run_traffic(4'b1110, 800, 60, 35, "R8");
        #1;
        check_eq("R1", "unused queue still full", DW'(in_ready[0]), 0);

        // R9: rejected configurations
        for (int k = 0; k < 3; k++) begin
            c = '0; c.op_en = 1; c.opcode = 4'd0; c.src_a = 3'd0; c.src_b = 3'd1; c.op_dst = 4'b0010;
            if (k == 0) begin c.byp_en[1] = 1; c.byp_src[1] = 2'd3; end
            if (k == 1) c.src_b = 3'd5;
            if (k == 2) begin c.op_en = 0; c.byp_en = 4'b0110; c.byp_src[1] = 2'd0; c.byp_src[2] = 2'd0; end
            do_reset(c);
            #1;
            check_eq("R9", $sformatf("bad config %0d flagged", k), DW'(cfg_err), 1);
            in_valid = 4'hF; in_data = {4{32'h5A5A_0000}}; out_ready = 4'hF;
            for (int t = 0; t < 4; t++) begin
                #1;
                check_eq("R9", "no output in fault", DW'(out_valid), 0);
                @(negedge clk);
            end
            #1;
            check_eq("R9", "queues not drained in fault", DW'(in_ready), 0);
            check_eq("R9", "fault sticky", DW'(cfg_err), 1);
            in_valid = '0;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule